// File: doc/BRIEF.md
# Instruction Cache Tag Unit

This block is a direct-mapped instruction cache for a 32-bit fetch path. It holds a tag array and a data array of 256 lines, four 32-bit words per line. Each tag entry carries one invalid flag per word, so a line can be partly valid. A fetch request is sorted by its segment bits into cacheable or uncached. A cacheable fetch is then looked up and either hits or starts a line fill.

A hit returns the word on the next clock and makes no memory request. A cacheable miss starts a partial line fill. The fill reads words one after another, from the requested word up to the last word of the line, through a simple request/acknowledge memory port. It then writes a tag in which every word before the starting word is flagged invalid. An uncached fetch makes exactly one memory read at the fetch address and leaves both arrays untouched. While a fill or a pass-through read is in progress the block lowers `fetch_ready` and ignores new requests.

Top module: `icache_tag_unit`

## Requirements
- R1: A fetch is cacheable exactly when `fetch_addr[31:29]` is 4 or less. Any other fetch issues one memory read with `mem_addr` equal to `fetch_addr` and returns that read's data.
- R2: The line is chosen by `fetch_addr[11:4]` (256 lines), and the word within the line by `fetch_addr[3:2]`. `fetch_addr[31:4]` is the tag address compared on lookup.
- R3: A lookup hits when the stored tag address equals `fetch_addr[31:4]` and the stored invalid flag for the requested word is 0. On a hit, `instr_valid` and `instr_hit` are high in the cycle after acceptance, the data is the stored word, and no memory request is made.
- R4: A cacheable miss starting at word w issues reads at `{fetch_addr[31:4], k, 2'b00}` for k = w, w+1, ..., 3, in that order, and writes each returned word into the line.
- R5: After a fill that starts at word 0, 1, 2 or 3, the line's invalid field (bit i for word i) is 4'b0000, 4'b0001, 4'b0011 or 4'b0111. Later fetches of words before the start word miss, and fetches of the filled words hit.
- R6: Reset sets every line's invalid field to 4'b1111, so the first fetch of any line misses. In reset, `fetch_ready` is 1 and `instr_valid` and `mem_req` are 0.
- R7: On a miss or an uncached fetch, `instr_valid` rises (with `instr_hit` = 0) in the cycle after the last memory acknowledge. `instr_data` is the memory word for the requested address.
- R8: `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen.
- R9: `fetch_ready` is low from the cycle after a miss or uncached fetch is accepted until `instr_valid` rises. A `fetch_valid` asserted during that time is ignored.
- R10: An uncached fetch changes no tag or data entry. A line that hit before it still hits afterwards and returns its old data.
- R11: A fetch whose line holds a different tag address misses, and its fill replaces that line. The old address then misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Virtual byte address of the instruction |
| fetch_ready | output | 1 | Block can accept a fetch this cycle |
| instr_valid | output | 1 | One-cycle pulse: instruction word returned |
| instr_data | output | 32 | Returned instruction word |
| instr_hit | output | 1 | Returned word came from the cache |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Word address of the memory read |
| mem_ack | input | 1 | Memory read completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The bench sends fetches that start at each of the four word offsets of a line. The length of each fill and the hit-or-miss pattern of the neighbouring words then show whether the invalid field is written correctly. Addresses just below and just above the cacheable limit (0x9FFF_FFFC and 0xA000_0000) separate the segment decode. Fetches that share an index but differ in tag address show replacement. Before an uncached read the memory content is changed, and a later cached hit must still return the old word, which shows that the pass-through path writes nothing. A random stream over a small address pool adds mixed hit/miss traffic. Throughout, memory acknowledges arrive with a varying delay.

// File: rtl/icache_pkg.sv
package icache_pkg;

  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int IDX_W      = 8;
  localparam int WORD_OFF_W = 2;
  localparam int BYTE_OFF_W = 2;
  localparam int WORDS      = 1 << WORD_OFF_W;
  localparam int LINES      = 1 << IDX_W;
  localparam int LINE_LSB   = BYTE_OFF_W + WORD_OFF_W;
  localparam int TAGA_W     = ADDR_W - LINE_LSB;
  localparam int SEG_W      = 3;
  localparam int SEG_LIMIT  = 4;

  typedef struct packed {
    logic [TAGA_W-1:0] taddr;
    logic [WORDS-1:0]  inv;
  } tag_entry_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_BYPASS = 2'd2
  } seq_state_t;

  function automatic logic f_cacheable(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SEG_W] <= SEG_W'(SEG_LIMIT);
  endfunction

  function automatic logic [IDX_W-1:0] f_line(input logic [ADDR_W-1:0] a);
    return a[LINE_LSB +: IDX_W];
  endfunction

  function automatic logic [WORD_OFF_W-1:0] f_word(input logic [ADDR_W-1:0] a);
    return a[BYTE_OFF_W +: WORD_OFF_W];
  endfunction

  function automatic logic [TAGA_W-1:0] f_tag_addr(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LINE_LSB];
  endfunction

  // Invalid field for a fill starting at word w: every word below w is flagged.
  function automatic logic [WORDS-1:0] f_fill_inv(input logic [WORD_OFF_W-1:0] w);
    logic [WORDS-1:0] r;
    for (int i = 0; i < WORDS; i++) r[i] = (i < int'(w));
    return r;
  endfunction

  function automatic logic f_hit(input tag_entry_t e, input logic [ADDR_W-1:0] a);
    return (e.taddr == f_tag_addr(a)) && !e.inv[f_word(a)];
  endfunction

  function automatic logic [ADDR_W-1:0] f_word_addr(input logic [TAGA_W-1:0] t,
                                                    input logic [WORD_OFF_W-1:0] w);
    return {t, w, {BYTE_OFF_W{1'b0}}};
  endfunction

endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store
  import icache_pkg::*;
#(
  parameter int N_LINES = LINES,
  localparam int IW     = $clog2(N_LINES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [IW-1:0] rd_idx,
  output tag_entry_t rd_entry,
  input  logic       we,
  input  logic [IW-1:0] wr_idx,
  input  tag_entry_t wr_entry
);

  tag_entry_t entry_q [N_LINES];

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entry_q[g].taddr <= '0;
        entry_q[g].inv   <= '1;
      end else if (we && (wr_idx == IW'(g))) begin
        entry_q[g] <= wr_entry;
      end
    end
  end

  assign rd_entry = entry_q[rd_idx];

  // A fill always runs to the last word, so that word is never flagged invalid.
  p_last_word_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !wr_entry.inv[WORDS-1]);

endmodule

// File: rtl/icache_word_store.sv
module icache_word_store
  import icache_pkg::*;
#(
  parameter int N_LINES = LINES,
  parameter int N_WORDS = WORDS,
  parameter int DW      = DATA_W,
  localparam int IW     = $clog2(N_LINES),
  localparam int WW     = $clog2(N_WORDS),
  localparam int DEPTH  = N_LINES * N_WORDS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  input  logic [WW-1:0] rd_word,
  output logic [DW-1:0] rd_data,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [WW-1:0] wr_word,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[{wr_idx, wr_word}] <= wr_data;
  end

  assign rd_data = mem_q[{rd_idx, rd_word}];

  p_fill_data_known_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !$isunknown(wr_data));

endmodule

// File: rtl/icache_fill_seq.sv
module icache_fill_seq
  import icache_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_fill,
  input  logic                  start_bypass,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  mem_ack,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  busy,
  output logic                  bypass_active,
  output logic                  mem_req,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  data_we,
  output logic [WORD_OFF_W-1:0] data_word,
  output logic                  tag_we,
  output logic [TAGA_W-1:0]     fill_taddr,
  output logic [WORD_OFF_W-1:0] fill_start,
  output logic                  done,
  output logic [DATA_W-1:0]     done_data
);

  seq_state_t              state_q;
  logic [ADDR_W-1:0]       base_q;
  logic [WORD_OFF_W-1:0]   ptr_q;
  logic [WORD_OFF_W-1:0]   start_q;
  logic [DATA_W-1:0]       hold_q;

  logic filling;
  logic last_word;
  logic fill_ack;
  logic bypass_ack;

  assign filling       = (state_q == ST_FILL);
  assign bypass_active = (state_q == ST_BYPASS);
  assign last_word     = (ptr_q == WORD_OFF_W'(WORDS - 1));
  assign fill_ack      = filling && mem_ack;
  assign bypass_ack    = bypass_active && mem_ack;

  assign busy       = (state_q != ST_IDLE);
  assign mem_req    = filling || bypass_active;
  assign mem_addr   = filling ? f_word_addr(f_tag_addr(base_q), ptr_q) : base_q;
  assign data_we    = fill_ack;
  assign data_word  = ptr_q;
  assign tag_we     = fill_ack && last_word;
  assign fill_taddr = f_tag_addr(base_q);
  assign fill_start = start_q;
  assign done       = tag_we || bypass_ack;
  assign done_data  = (bypass_active || (ptr_q == start_q)) ? mem_rdata : hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      ptr_q   <= '0;
      start_q <= '0;
      hold_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_fill) begin
            state_q <= ST_FILL;
            base_q  <= req_addr;
            ptr_q   <= f_word(req_addr);
            start_q <= f_word(req_addr);
          end else if (start_bypass) begin
            state_q <= ST_BYPASS;
            base_q  <= req_addr;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            if (ptr_q == start_q) hold_q <= mem_rdata;
            if (last_word) state_q <= ST_IDLE;
            else           ptr_q   <= ptr_q + 1'b1;
          end
        end
        ST_BYPASS: begin
          if (mem_ack) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_fill_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ack && !last_word) |=> (filling && ptr_q == $past(ptr_q) + 1'b1));

  p_fill_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    filling |-> (ptr_q >= start_q));

endmodule

// File: rtl/icache_tag_unit.sv
module icache_tag_unit
  import icache_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fetch_valid,
  input  logic [31:0] fetch_addr,
  output logic        fetch_ready,
  output logic        instr_valid,
  output logic [31:0] instr_data,
  output logic        instr_hit,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);

  // Named internal events
  logic       busy;
  logic       accept;
  logic       cacheable;
  logic       lookup_hit;
  logic       hit_accept;
  logic       miss_accept;
  logic       bypass_accept;
  logic       bypass_active;

  tag_entry_t             rd_entry;
  tag_entry_t             wr_entry;
  logic [DATA_W-1:0]      rd_word_data;
  logic                   data_we;
  logic [WORD_OFF_W-1:0]  data_word;
  logic                   tag_we;
  logic [TAGA_W-1:0]      fill_taddr;
  logic [WORD_OFF_W-1:0]  fill_start;
  logic [IDX_W-1:0]       fill_line;
  logic                   fill_done;
  logic [DATA_W-1:0]      fill_data;

  assign accept        = fetch_valid && !busy;
  assign cacheable     = f_cacheable(fetch_addr);
  assign lookup_hit    = f_hit(rd_entry, fetch_addr);
  assign hit_accept    = accept && cacheable && lookup_hit;
  assign miss_accept   = accept && cacheable && !lookup_hit;
  assign bypass_accept = accept && !cacheable;
  assign fetch_ready   = !busy;

  assign fill_line      = fill_taddr[IDX_W-1:0];
  assign wr_entry.taddr = fill_taddr;
  assign wr_entry.inv   = f_fill_inv(fill_start);

  icache_tag_store #(.N_LINES(LINES)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (f_line(fetch_addr)),
    .rd_entry (rd_entry),
    .we       (tag_we),
    .wr_idx   (fill_line),
    .wr_entry (wr_entry)
  );

  icache_word_store #(.N_LINES(LINES), .N_WORDS(WORDS), .DW(DATA_W)) u_words (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (f_line(fetch_addr)),
    .rd_word (f_word(fetch_addr)),
    .rd_data (rd_word_data),
    .we      (data_we),
    .wr_idx  (fill_line),
    .wr_word (data_word),
    .wr_data (mem_rdata)
  );

  icache_fill_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_fill    (miss_accept),
    .start_bypass  (bypass_accept),
    .req_addr      (fetch_addr),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .busy          (busy),
    .bypass_active (bypass_active),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .data_we       (data_we),
    .data_word     (data_word),
    .tag_we        (tag_we),
    .fill_taddr    (fill_taddr),
    .fill_start    (fill_start),
    .done          (fill_done),
    .done_data     (fill_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      instr_valid <= 1'b0;
      instr_hit   <= 1'b0;
      instr_data  <= '0;
    end else begin
      instr_valid <= hit_accept || fill_done;
      instr_hit   <= hit_accept;
      if (hit_accept)     instr_data <= rd_word_data;
      else if (fill_done) instr_data <= fill_data;
    end
  end

  p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_accept |=> (instr_valid && instr_hit && !mem_req));

  p_uncached_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_accept |=> (mem_req && mem_addr == $past(fetch_addr)));

  p_bypass_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_active |-> (!tag_we && !data_we));

  p_busy_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_accept || bypass_accept) |=> (!fetch_ready && !instr_valid));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (instr_valid && !instr_hit && fetch_ready));

endmodule

// File: tb/test_icache_tag_unit.sv
module test_icache_tag_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic        fetch_ready;
  logic        instr_valid;
  logic [31:0] instr_data;
  logic        instr_hit;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  always #10 clk = ~clk;

  icache_tag_unit i_icache_tag_unit (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .instr_valid(instr_valid), .instr_data(instr_data), .instr_hit(instr_hit),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int failures = 0;
  int fetches = 0;
  int pulses = 0;
  int epoch = 0;
  bit finished = 0;

  // Behavioural reference state
  logic [27:0] m_tag  [256];
  logic [3:0]  m_inv  [256];
  logic [31:0] m_data [1024];
  logic [31:0] exp_q[$];
  logic [31:0] obs_q[$];

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return (a ^ 32'(epoch)) * 32'h0100_0193 + 32'h1234_5678;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder: varying acknowledge delay, stability check while waiting
  int lat_pat = 0;
  int lat = 0;
  int cnt = 0;
  bit waiting = 0;
  logic [31:0] held_addr;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; waiting = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (!waiting) begin
        waiting = 1; held_addr = mem_addr; cnt = 0;
        lat = lat_pat; lat_pat = (lat_pat + 1) % 3;
      end else begin
        check(mem_addr == held_addr, "R8 address stable", mem_addr, held_addr);
      end
      if (cnt >= lat) begin
        mem_ack = 1'b1;
        mem_rdata = mem_val(mem_addr);
        obs_q.push_back(mem_addr);
        waiting = 0;
      end else cnt++;
    end
  end

  always @(negedge clk) if (rst_n && instr_valid) pulses++;

  task automatic do_fetch(input logic [31:0] a);
    bit cach, hit, last_ack, seen;
    int line, w;
    logic [31:0] exp_d;
    cach = (a[31:29] <= 3'd4);
    line = int'(a[11:4]);
    w    = int'(a[3:2]);
    hit  = cach && (m_tag[line] == a[31:4]) && !m_inv[line][w];
    exp_q.delete();
    obs_q.delete();
    if (!cach) exp_q.push_back(a);
    else if (!hit) for (int k = w; k < 4; k++) exp_q.push_back({a[31:4], 2'(k), 2'b00});
    check(fetch_ready, "R9 ready when idle", 32'(fetch_ready), 1);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    @(negedge clk); #1;
    if (hit) begin
      fetch_valid = 1'b0;
      exp_d = m_data[line*4 + w];
      check(instr_valid && instr_hit, "R3 hit next cycle", {30'd0, instr_valid, instr_hit}, 32'h3);
      check(instr_data == exp_d, "R3 hit data", instr_data, exp_d);
    end else begin
      fetch_addr = a ^ 32'h0000_0230;   // competing request that must be ignored
      seen = 0; last_ack = 0;
      for (int n = 0; n < 60; n++) begin
        if (instr_valid) begin seen = 1; break; end
        if (!fetch_ready == 1'b0) check(0, "R9 busy", 32'(fetch_ready), 0);
        last_ack = mem_ack;
        @(negedge clk); #1;
      end
      fetch_valid = 1'b0;
      check(seen, "R7 response arrives", 32'(seen), 1);
      check(last_ack, "R7 response one cycle after last ack", 32'(last_ack), 1);
      check(!instr_hit, "R7 miss flagged", 32'(instr_hit), 0);
      exp_d = mem_val(a & 32'hFFFF_FFFC);
      if (!cach) exp_d = mem_val(a);
      check(instr_data == exp_d, cach ? "R4 fill data" : "R1 uncached data", instr_data, exp_d);
      if (cach) begin
        for (int k = w; k < 4; k++) m_data[line*4 + k] = mem_val({a[31:4], 2'(k), 2'b00});
        m_tag[line] = a[31:4];
        m_inv[line] = 4'((1 << w) - 1);
      end
    end
    check(obs_q.size() == exp_q.size(), cach ? "R4 read count" : "R1 read count",
          32'(obs_q.size()), 32'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
      check(obs_q[i] == exp_q[i], cach ? "R4 read address" : "R1 read address", obs_q[i], exp_q[i]);
    fetches++;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_tag[i] = '0; m_inv[i] = 4'hF; end
    rst_n = 1'b0; fetch_valid = 1'b0; fetch_addr = '0; mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    #1;
    check(fetch_ready && !instr_valid && !mem_req, "R6 reset outputs",
          {29'd0, fetch_ready, instr_valid, mem_req}, 32'h4);
    @(negedge clk); rst_n = 1'b1; #1;

    // R6: tag address 0 matches reset state but invalid flags force a miss
    do_fetch(32'h0000_0000);
    // R3/R5: start at word 0 -> all words valid
    do_fetch(32'h0000_0004);
    do_fetch(32'h0000_0008);
    do_fetch(32'h0000_000C);
    // R2/R5: start at word 2 in a cached kernel address, line index 0x23
    do_fetch(32'h8000_1238);
    do_fetch(32'h8000_123C);
    do_fetch(32'h8000_1234);  // word 1 flagged invalid -> fill words 1..3
    do_fetch(32'h8000_1230);  // word 0 still invalid -> fill 0..3
    do_fetch(32'h8000_1230);  // now hits
    // R5: start at word 1 and word 3
    do_fetch(32'h0040_0554);
    do_fetch(32'h0040_0550);
    do_fetch(32'h0000_0A7C);
    do_fetch(32'h0000_0A78);
    // R10: change memory, then uncached reads; cached line must keep old data
    epoch = 5;
    do_fetch(32'hA000_0004);
    do_fetch(32'hFFFF_0008);
    do_fetch(32'h0000_0004);
    // R1 boundaries
    do_fetch(32'h9FFF_FFFC);
    do_fetch(32'h9FFF_FFFC);
    do_fetch(32'hA000_0000);
    do_fetch(32'hC000_0010);
    // R11: same index, different tag address evicts
    do_fetch(32'h0001_0008);
    do_fetch(32'h0000_0008);
    do_fetch(32'h0001_0008);

    // Mixed random stream over a small address pool
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      logic [2:0] sel;
      sel = 3'($urandom_range(0, 7));
      a = {sel, 29'd0} | {14'd0, 2'($urandom_range(0, 3)), 16'd0}
        | {20'd0, 2'($urandom_range(0, 3)), 6'd0, 2'($urandom_range(0, 3)), 2'b00};
      if ((i % 50) == 49) epoch++;
      do_fetch(a);
    end

    repeat (2) @(negedge clk);
    check(pulses == fetches, "R7 one response per fetch", 32'(pulses), 32'(fetches));
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule